// File: doc/BRIEF.md
# Serial-Loaded Four-Channel Level Register

This block holds a 5-bit level for each of four channels. A host loads the levels through a three-wire serial port: a data line, the shift clock and an active-low load enable. Bits go into a 21-stage shift chain that is kept apart from the active register. The chain contents are copied into the active register only when the enable returns high. The last chain stage is driven out on a data-out line, so several devices can share one clock and one enable and form a daisy chain.

Each channel also has a strap word of three digits. The first digit has two states and the other two have three states. A fixed table maps the word to one of 18 of the 32 levels. The first chain stage is an override flag. While the committed flag is clear, or while the mode input is low, the strap levels drive the outputs. A low mode input also holds every internal register at zero. The serial clock is the only clock, and the enable is sampled on it.

Top module: `seq_prog_reg`

## Requirements
- R1: On a rising clock edge with mode_i high and sen_ni low, sdi_i enters stage 1 and every stage moves one place higher. When more than 21 bits are shifted, only the last 21 are kept.
- R2: Stage 1 is the override flag. Stages 2-6, 7-11, 12-16 and 17-21 hold the levels of channels 0, 1, 2 and 3, and the lowest stage of each group is the LSB. The host sends stage 21 first and stage 1 last. level_o[5k+4:5k] is the level of channel k.
- R3: While sen_ni is low, shifting has no effect on level_o.
- R4: The chain is copied into the active register exactly once, on the first rising clock edge at which sen_ni is sampled high after it was sampled low, provided mode_i is high at that edge.
- R5: While mode_i is low, the strap levels drive level_o at once, and every clock edge clears the chain and the active register. Shifting and commit are ignored while mode_i is low.
- R6: After rst_ni is asserted, all registers are zero, sdo_o is 0, and level_o shows the strap levels.
- R7: Strap codes: A is 0=LOW, 1=HIGH. B and C are 00=LOW, 01=MID, 10=HIGH. The mapping is LLL0 LLM2 LLH4 LML6 LMM8 LMH10 LHL12 LHM14 LHH15 HLL16 HLM17 HLH19 HML21 HMM23 HMH24 HHL26 HHM28 HHH31.
- R8: The unused B/C code 11 decodes as HIGH.
- R9: sdo_o shows stage 21. It is a registered output, so it repeats sdi_i 21 shift edges later. After a clear it is 0.
- R10: After a commit with the override flag clear, level_o shows the strap levels. After a commit with the flag set, level_o shows the committed fields.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Serial shift clock (the only clock) |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mode_i | input | 1 | High enables serial control; low clears all state and selects straps |
| sen_ni | input | 1 | Serial load enable, active low |
| sdi_i | input | 1 | Serial data in |
| sdo_o | output | 1 | Serial data out (stage 21) |
| strap_a_i | input | 4 | Two-level strap digit A, one bit per channel |
| strap_b_i | input | 8 | Three-level strap digit B, 2-bit code per channel |
| strap_c_i | input | 8 | Three-level strap digit C, 2-bit code per channel |
| level_o | output | 20 | Active 5-bit level per channel |

## Verification
The hardest case to reach is the two-device daisy chain. The far device only sees bits after they have passed all 21 stages of the near device, and both devices must commit on the same enable edge. The bench wires a second instance behind the first and shifts 42 bits, far-device word first, then raises the shared enable once and checks both devices. The retention of only the last 21 bits is reached by shifting a 9-bit junk prefix before a full word. The 21-edge data-out delay is checked edge by edge after a mode-low clear, so the expected prefix is all zeros.

// File: rtl/seq_prog_pkg.sv
package seq_prog_pkg;
  localparam int unsigned STRAP_CNT = 18;

  // idx = a*9 + b*3 + c, each ternary digit 0..2
  function automatic logic [4:0] strap_level(input logic [4:0] idx);
    logic [4:0] lvl;
    case (idx)
      5'd0:  lvl = 5'd0;
      5'd1:  lvl = 5'd2;
      5'd2:  lvl = 5'd4;
      5'd3:  lvl = 5'd6;
      5'd4:  lvl = 5'd8;
      5'd5:  lvl = 5'd10;
      5'd6:  lvl = 5'd12;
      5'd7:  lvl = 5'd14;
      5'd8:  lvl = 5'd15;
      5'd9:  lvl = 5'd16;
      5'd10: lvl = 5'd17;
      5'd11: lvl = 5'd19;
      5'd12: lvl = 5'd21;
      5'd13: lvl = 5'd23;
      5'd14: lvl = 5'd24;
      5'd15: lvl = 5'd26;
      5'd16: lvl = 5'd28;
      default: lvl = 5'd31;
    endcase
    return lvl;
  endfunction

  function automatic logic [1:0] tern_norm(input logic [1:0] code);
    return (code == 2'b11) ? 2'b10 : code;
  endfunction
endpackage

// File: rtl/seq_shift_chain.sv
module seq_shift_chain #(
  parameter int unsigned CW = 21
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          mode_i,
  input  logic          sen_ni,
  input  logic          sdi_i,
  output logic [CW-1:0] chain_o,
  output logic          sdo_o
);
  logic [CW-1:0] chain_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      chain_q <= '0;
    else if (!mode_i) chain_q <= '0;
    else if (!sen_ni) chain_q <= {chain_q[CW-2:0], sdi_i};
  end

  assign chain_o = chain_q;
  assign sdo_o   = chain_q[CW-1];
endmodule

// File: rtl/seq_commit_ctrl.sv
module seq_commit_ctrl #(
  parameter int unsigned CW = 21
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          mode_i,
  input  logic          sen_ni,
  input  logic [CW-1:0] chain_i,
  output logic [CW-1:0] active_o
);
  logic          sen_q;
  logic          commit;
  logic [CW-1:0] active_q;

  // Previous enable sample; forced high in mode low so mode edges never commit
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      sen_q <= 1'b1;
    else if (!mode_i) sen_q <= 1'b1;
    else              sen_q <= sen_ni;
  end

  assign commit = mode_i & ~sen_q & sen_ni;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      active_q <= '0;
    else if (!mode_i) active_q <= '0;
    else if (commit)  active_q <= chain_i;
  end

  assign active_o = active_q;
endmodule

// File: rtl/seq_strap_decode.sv
module seq_strap_decode
  import seq_prog_pkg::*;
#(
  parameter int unsigned LW = 5
) (
  input  logic          a_i,
  input  logic [1:0]    b_i,
  input  logic [1:0]    c_i,
  output logic [LW-1:0] level_o
);
  logic [1:0] bt, ct;
  logic [4:0] idx;

  always_comb begin
    bt  = tern_norm(b_i);
    ct  = tern_norm(c_i);
    idx = (a_i ? 5'd9 : 5'd0) + ({3'b0, bt} * 5'd3) + {3'b0, ct};
    level_o = LW'(strap_level(idx));
  end
endmodule

// File: rtl/seq_prog_reg.sv
module seq_prog_reg #(
  parameter int unsigned NCH = 4,
  parameter int unsigned LW  = 5
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              mode_i,
  input  logic              sen_ni,
  input  logic              sdi_i,
  output logic              sdo_o,
  input  logic [NCH-1:0]    strap_a_i,
  input  logic [2*NCH-1:0]  strap_b_i,
  input  logic [2*NCH-1:0]  strap_c_i,
  output logic [NCH*LW-1:0] level_o
);
  localparam int unsigned CHAIN_W = 1 + NCH * LW;

  logic [CHAIN_W-1:0] chain_q;
  logic [CHAIN_W-1:0] active_q;
  logic               use_ser;

  seq_shift_chain #(.CW(CHAIN_W)) u_chain (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .mode_i  (mode_i),
    .sen_ni  (sen_ni),
    .sdi_i   (sdi_i),
    .chain_o (chain_q),
    .sdo_o   (sdo_o)
  );

  seq_commit_ctrl #(.CW(CHAIN_W)) u_commit (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .mode_i   (mode_i),
    .sen_ni   (sen_ni),
    .chain_i  (chain_q),
    .active_o (active_q)
  );

  // Mode low selects straps immediately, ahead of the synchronous clear
  assign use_ser = mode_i & active_q[0];

  for (genvar k = 0; k < NCH; k++) begin : g_ch
    logic [LW-1:0] strap_lvl;

    seq_strap_decode #(.LW(LW)) u_dec (
      .a_i     (strap_a_i[k]),
      .b_i     (strap_b_i[2*k +: 2]),
      .c_i     (strap_c_i[2*k +: 2]),
      .level_o (strap_lvl)
    );

    assign level_o[k*LW +: LW] = use_ser ? active_q[1 + k*LW +: LW] : strap_lvl;
  end
endmodule

// File: rtl/seq_prog_reg_chk.sv
module seq_prog_reg_chk #(
  parameter int unsigned CW = 21
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          mode_i,
  input logic          sen_ni,
  input logic          sdi_i,
  input logic          sdo_o,
  input logic [CW-1:0] chain_q,
  input logic [CW-1:0] active_q
);
  assert_shift_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i && !sen_ni) |=> (chain_q == {$past(chain_q[CW-2:0]), $past(sdi_i)}));

  assert_hold_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i && !sen_ni) |=> $stable(active_q));

  assert_commit_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i && !sen_ni) ##1 (mode_i && sen_ni) |=> (active_q == $past(chain_q)));

  assert_clear_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !mode_i |=> (chain_q == '0 && active_q == '0 && !sdo_o));

  assert_sdo_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i && !sen_ni) |=> (sdo_o == $past(chain_q[CW-2])));
endmodule

bind seq_prog_reg seq_prog_reg_chk u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .mode_i   (mode_i),
  .sen_ni   (sen_ni),
  .sdi_i    (sdi_i),
  .sdo_o    (sdo_o),
  .chain_q  (chain_q),
  .active_q (active_q)
);

// File: tb/tb_seq_prog_reg.sv
`timescale 1ns/1ps
module tb_seq_prog_reg;
  localparam int NCH = 4;
  localparam int LW  = 5;
  localparam int CW  = 1 + NCH * LW;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic mode = 1'b0;
  logic sen_n = 1'b1;
  logic sdi = 1'b0;
  logic sdo, sdo2;
  logic [NCH-1:0]    sa;
  logic [2*NCH-1:0]  sb, sc;
  logic [NCH*LW-1:0] lvl, lvl2;

  int errors = 0;
  int checks = 0;

  always #5 clk = ~clk;

  seq_prog_reg dut (
    .clk_i(clk), .rst_ni(rst_n), .mode_i(mode), .sen_ni(sen_n), .sdi_i(sdi),
    .sdo_o(sdo), .strap_a_i(sa), .strap_b_i(sb), .strap_c_i(sc), .level_o(lvl)
  );

  seq_prog_reg dut2 (
    .clk_i(clk), .rst_ni(rst_n), .mode_i(mode), .sen_ni(sen_n), .sdi_i(sdo),
    .sdo_o(sdo2), .strap_a_i(sa), .strap_b_i(sb), .strap_c_i(sc), .level_o(lvl2)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int exp_strap(input int a, input int b, input int c);
    int bb, cc;
    bb = (b == 3) ? 2 : b;
    cc = (c == 3) ? 2 : c;
    case (a * 9 + bb * 3 + cc)
      0: return 0;   1: return 2;   2: return 4;   3: return 6;
      4: return 8;   5: return 10;  6: return 12;  7: return 14;
      8: return 15;  9: return 16;  10: return 17; 11: return 19;
      12: return 21; 13: return 23; 14: return 24; 15: return 26;
      16: return 28; default: return 31;
    endcase
  endfunction

  function automatic int strap_exp(input int k);
    return exp_strap(int'(sa[k]), int'(sb[2*k +: 2]), int'(sc[2*k +: 2]));
  endfunction

  function automatic logic [CW-1:0] mk_word(input logic ovr, input int l0, input int l1,
                                            input int l2, input int l3);
    return {LW'(l3), LW'(l2), LW'(l1), LW'(l0), ovr};
  endfunction

  task automatic set_strap(input int k, input int a, input int b, input int c);
    sa[k] = 1'(a);
    sb[2*k +: 2] = 2'(b);
    sc[2*k +: 2] = 2'(c);
  endtask

  task automatic shift_bit(input logic b);
    @(negedge clk);
    sen_n = 1'b0;
    sdi = b;
    @(posedge clk);
    #1;
  endtask

  task automatic shift_word(input logic [CW-1:0] w);
    for (int i = CW - 1; i >= 0; i--) shift_bit(w[i]);
  endtask

  task automatic commit();
    @(negedge clk);
    sen_n = 1'b1;
    @(posedge clk);
    #1;
  endtask

  task automatic clear_mode();
    @(negedge clk);
    mode = 1'b0;
    sen_n = 1'b1;
    @(posedge clk);
    @(negedge clk);
    mode = 1'b1;
  endtask

  task automatic check_straps(input string req);
    for (int k = 0; k < NCH; k++) check(req, int'(lvl[k*LW +: LW]), strap_exp(k));
  endtask

  task automatic check_levels(input string req, input int l0, input int l1,
                              input int l2, input int l3);
    check(req, int'(lvl[0 +: LW]), l0);
    check(req, int'(lvl[LW +: LW]), l1);
    check(req, int'(lvl[2*LW +: LW]), l2);
    check(req, int'(lvl[3*LW +: LW]), l3);
  endtask

  task automatic t_reset();
    #1;
    check_straps("R6 reset strap levels");
    check("R6 reset sdo", int'(sdo), 0);
  endtask

  task automatic t_strap_table();
    for (int a = 0; a < 2; a++)
      for (int b = 0; b < 3; b++)
        for (int c = 0; c < 3; c++) begin
          set_strap(0, a, b, c);
          set_strap(3, 1 - a, 2 - b, c);
          #1;
          check("R7 strap ch0", int'(lvl[0 +: LW]), exp_strap(a, b, c));
          check("R7 strap ch3", int'(lvl[3*LW +: LW]), exp_strap(1 - a, 2 - b, c));
        end
    set_strap(1, 1, 3, 3);
    #1;
    check("R8 code 11 as HIGH (HHH)", int'(lvl[LW +: LW]), 31);
    set_strap(1, 0, 3, 1);
    #1;
    check("R8 code 11 as HIGH (LHM)", int'(lvl[LW +: LW]), 14);
    set_strap(0, 1, 1, 2);
    set_strap(1, 0, 2, 1);
    set_strap(2, 0, 0, 1);
    set_strap(3, 1, 2, 2);
  endtask

  task automatic t_load_commit();
    shift_word(mk_word(1'b1, 3, 17, 30, 9));
    check_straps("R3 no effect while enable low");
    commit();
    check_levels("R2 R4 committed fields", 3, 17, 30, 9);
    for (int i = 0; i < 5; i++) shift_bit(1'b0);
    check_levels("R3 held during next shift", 3, 17, 30, 9);
    commit();
    check("R4 commit of partial shift", int'(lvl[0 +: LW]), strap_exp(0));
  endtask

  task automatic t_last21();
    logic [8:0] junk = 9'b101101110;
    clear_mode();
    for (int i = 8; i >= 0; i--) shift_bit(junk[i]);
    shift_word(mk_word(1'b1, 31, 0, 21, 5));
    commit();
    check_levels("R1 last 21 bits kept", 31, 0, 21, 5);
  endtask

  task automatic t_override_clear();
    shift_word(mk_word(1'b0, 7, 8, 9, 10));
    commit();
    check_straps("R10 override clear selects straps");
  endtask

  task automatic t_mode_low();
    shift_word(mk_word(1'b1, 1, 2, 3, 4));
    commit();
    check_levels("R10 override set", 1, 2, 3, 4);
    @(negedge clk);
    mode = 1'b0;
    #1;
    check_straps("R5 mode low selects straps at once");
    for (int i = 0; i < CW; i++) shift_bit(1'b1);
    commit();
    check("R5 sdo after mode-low shifting", int'(sdo), 0);
    @(negedge clk);
    mode = 1'b1;
    shift_bit(1'b0);
    commit();
    check_straps("R5 state cleared, shifting ignored");
  endtask

  task automatic t_sdo_delay();
    logic [29:0] pat = 30'h2D3A_5C71;
    clear_mode();
    for (int n = 0; n < 30; n++) begin
      shift_bit(pat[n]);
      if (n < CW - 1) check("R9 sdo zero after clear", int'(sdo), 0);
      else check("R9 sdo delayed 21 edges", int'(sdo), int'(pat[n - (CW - 1)]));
    end
    commit();
  endtask

  task automatic t_daisy();
    clear_mode();
    shift_word(mk_word(1'b1, 11, 22, 6, 27));
    shift_word(mk_word(1'b1, 19, 4, 25, 13));
    commit();
    check_levels("R9 daisy near device", 19, 4, 25, 13);
    check("R9 daisy far ch0", int'(lvl2[0 +: LW]), 11);
    check("R9 daisy far ch1", int'(lvl2[LW +: LW]), 22);
    check("R9 daisy far ch2", int'(lvl2[2*LW +: LW]), 6);
    check("R9 daisy far ch3", int'(lvl2[3*LW +: LW]), 27);
  endtask

  initial begin
    sa = '0; sb = '0; sc = '0;
    set_strap(0, 1, 1, 2);
    set_strap(1, 0, 2, 1);
    set_strap(2, 0, 0, 1);
    set_strap(3, 1, 2, 2);
    #23;
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    mode = 1'b1;
    t_strap_table();
    t_load_commit();
    t_last21();
    t_override_clear();
    t_mode_low();
    t_sdo_delay();
    t_daisy();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #2000000;
    errors++;
    checks++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule